// File: doc/BRIEF.md
# Byte-Port Frame Network Interface

This block sits on a simple single-cycle register bus. A host moves Ethernet frames through it one byte at a time. One frame buffer holds the most recent inbound frame. The host drains that buffer through a single receive data register whose pointer advances on every read. A second buffer collects an outbound frame through a single transmit data register. Once the announced length has been written, the block plays the frame out on a byte stream.

Inbound frames arrive on a byte stream with valid, last and ready. Outbound frames leave on a matching stream. Two flags report completed transfers: one for a sent frame and one for a received frame. A third flag is a test flag, whose set command also performs a soft reset. A level interrupt is high while any of the three flags is set. Busy status follows the pending flags. While busy is set, the block refuses new inbound frames. After reset the block is busy, so the host must write the interrupt control register before any frame can come in.

Top module: `nbx_byte_nic`

## Requirements
- R1: The bus address is reduced to its low 6 bits. Reads return the following:
  - 0x00 returns 0x4D495053 and 0x04 returns 0x4E455430.
  - 0x08 returns busy, 0x0C the receive count and 0x10 the transmit count.
  - 0x14 returns interrupt control.
  - 0x18, 0x20 and every unmapped offset return zero.
  - Read data appears on the bus one cycle after the read strobe.
- R2: After reset, busy reads 1. Both counts and interrupt control read 0. The interrupt output is low, the inbound ready is low and the outbound valid is low.
- R3: Interrupt control bit 0 is transmit-done, bit 1 is receive-done and bit 31 is the test flag. The interrupt output is high exactly while any of these bits is set.
- R4: A read of interrupt control returns the value held before the read, and then clears bit 31.
- R5: A write to interrupt control is decoded by priority:
  - If bit 0 is set, only transmit-done is cleared.
  - Otherwise, if bit 1 is set, only receive-done is cleared.
  - Otherwise, if bit 31 is set, a soft reset (R14) runs and bit 31 is then set.
  - A write of zero changes no flag.
- R6: After any write to interrupt control, busy reads 1 if a flag is still set and 0 if none is.
- R7: A new inbound frame is taken only while busy is 0 and the receive count is below 1514. Otherwise ready stays low and no byte is taken.
- R8: When the last byte of an accepted frame is taken, the following happens:
  - The receive count becomes the frame length.
  - The read pointer returns to the first byte.
  - Receive-done and busy are set.
- R9: An inbound frame longer than 1514 bytes is fully consumed. Only its first 1514 bytes are stored, and the count stops at 1514.
- R10: Each read of 0x1C returns the next stored byte in bits 7:0, advances the read pointer and decrements the receive count. When the count is zero, the read returns 0 and changes nothing.
- R11: A write to 0x10 loads the transmit count if the value is at most 1514, and loads 0 otherwise. In both cases it rewinds the transmit write pointer.
- R12: A write to 0x20 stores bits 7:0. When the number of stored bytes reaches the transmit count, the following happens:
  - Both the count and the pointer return to 0.
  - The bytes leave in order, with last on the final byte only, and the data stays stable while ready is low.
  - Transmit-done and busy are set only once the last byte is taken.
- R13: While an outbound frame is still draining, writes to 0x10 and 0x20 are ignored. A write to 0x20 is also ignored while the transmit count is 0.
- R14: A soft reset clears the following:
  - both counts and both pointers;
  - any frame being received or sent;
  - all flags.
  It leaves busy at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, low 6 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rxs_data | input | 8 | Inbound frame byte |
| rxs_valid | input | 1 | Inbound byte valid |
| rxs_last | input | 1 | Inbound byte is the final one of its frame |
| rxs_ready | output | 1 | Block takes the inbound byte |
| txs_data | output | 8 | Outbound frame byte |
| txs_valid | output | 1 | Outbound byte valid |
| txs_last | output | 1 | Outbound byte is the final one of its frame |
| txs_ready | input | 1 | Sink takes the outbound byte |
| irq | output | 1 | Level interrupt, high while any flag is set |

## Verification
The bench targets the cases below. Each case names the error that it catches.

**Acknowledge priority.** The bench writes patterns with several bits set. A decoder without priority would clear both done flags at once, or would soft-reset on 0x80000003.

**Receive limit.** A frame of 1520 bytes must leave a count of exactly 1514 and the correct byte at position 1513. A missing clamp would wrap the count or overrun the buffer. The bench also checks that a full buffer refuses the next frame even while busy is 0.

**Boundary reads.** The bench reads at a zero receive count, and reads the test flag twice. A design that advances or clears on the wrong condition would return stale bytes, or would keep the interrupt asserted.

**Transmit drain.** The bench stalls the outbound stream and writes again during the drain. A design that raised transmit-done early, or that accepted those writes, would show a wrong flag or a nonzero count.

// File: rtl/nbx_pkg.sv
package nbx_pkg;

  // register offsets after the 6-bit address mask
  localparam logic [5:0] OFS_ID_HI  = 6'h00;
  localparam logic [5:0] OFS_ID_LO  = 6'h04;
  localparam logic [5:0] OFS_BUSY   = 6'h08;
  localparam logic [5:0] OFS_RXCNT  = 6'h0C;
  localparam logic [5:0] OFS_TXCNT  = 6'h10;
  localparam logic [5:0] OFS_INTCTL = 6'h14;
  localparam logic [5:0] OFS_INFO   = 6'h18;
  localparam logic [5:0] OFS_RXDATA = 6'h1C;
  localparam logic [5:0] OFS_TXDATA = 6'h20;

  localparam logic [31:0] IDENT_HI = 32'h4D49_5053;
  localparam logic [31:0] IDENT_LO = 32'h4E45_5430;

  // interrupt control bit positions
  localparam int TXD_BIT = 0;
  localparam int RXD_BIT = 1;
  localparam int TST_BIT = 31;

endpackage

// File: rtl/nbx_rst_sync.sv
module nbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/nbx_rx_path.sv
module nbx_rx_path #(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             accept_ok,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  output logic             active,
  input  logic             pop,
  output logic             frame_done,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       rd_byte
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FRAME_MAX);

  logic [7:0]       mem [FRAME_MAX];
  logic             active_q, active_n;
  logic [CNT_W-1:0] wlen_q, wlen_n;
  logic [CNT_W-1:0] count_q, count_n;
  logic [CNT_W-1:0] rptr_q, rptr_n;
  logic             beat, mem_we, pop_ok;
  logic [CNT_W-1:0] final_len;

  assign s_ready    = active_q | accept_ok;
  assign beat       = s_valid & s_ready;
  assign mem_we     = beat & ~soft_clr & (wlen_q < MAX_C);
  assign frame_done = beat & s_last & ~soft_clr;
  assign pop_ok     = pop & (count_q != '0) & ~frame_done;
  assign final_len  = (wlen_q == MAX_C) ? wlen_q : wlen_q + 1'b1;

  always_comb begin
    active_n = active_q;
    wlen_n   = wlen_q;
    count_n  = count_q;
    rptr_n   = rptr_q;
    if (soft_clr) begin
      active_n = 1'b0;
      wlen_n   = '0;
      count_n  = '0;
      rptr_n   = '0;
    end else begin
      if (beat) begin
        active_n = ~s_last;
        if (s_last)              wlen_n = '0;
        else if (wlen_q < MAX_C) wlen_n = wlen_q + 1'b1;
      end
      if (frame_done) begin
        count_n = final_len;
        rptr_n  = '0;
      end else if (pop_ok) begin
        count_n = count_q - 1'b1;
        rptr_n  = rptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wlen_q   <= '0;
      count_q  <= '0;
      rptr_q   <= '0;
    end else begin
      active_q <= active_n;
      wlen_q   <= wlen_n;
      count_q  <= count_n;
      rptr_q   <= rptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wlen_q] <= s_data;
  end

  assign active  = active_q;
  assign count   = count_q;
  assign rd_byte = mem[rptr_q];

endmodule

// File: rtl/nbx_tx_path.sv
module nbx_tx_path #(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             cnt_wr,
  input  logic [31:0]      cnt_val,
  input  logic             dat_wr,
  input  logic [7:0]       dat_val,
  output logic [7:0]       m_data,
  output logic             m_valid,
  output logic             m_last,
  input  logic             m_ready,
  output logic [CNT_W-1:0] count,
  output logic             sent
);

  logic [7:0]       mem [FRAME_MAX];
  logic [CNT_W-1:0] count_q, count_n;
  logic [CNT_W-1:0] wptr_q, wptr_n;
  logic [CNT_W-1:0] dlen_q, dlen_n;
  logic [CNT_W-1:0] dptr_q, dptr_n;
  logic             drain_q, drain_n;
  logic             wr_ok, mem_we, cnt_ok;

  assign cnt_ok  = cnt_wr & ~drain_q & ~soft_clr;
  assign wr_ok   = dat_wr & ~drain_q & ~soft_clr & (count_q != '0);
  assign mem_we  = wr_ok;
  assign m_valid = drain_q;
  assign m_data  = mem[dptr_q];
  assign m_last  = drain_q & (dptr_q + 1'b1 == dlen_q);
  assign sent    = drain_q & m_ready & m_last & ~soft_clr;

  always_comb begin
    count_n = count_q;
    wptr_n  = wptr_q;
    dlen_n  = dlen_q;
    dptr_n  = dptr_q;
    drain_n = drain_q;
    if (soft_clr) begin
      count_n = '0;
      wptr_n  = '0;
      dlen_n  = '0;
      dptr_n  = '0;
      drain_n = 1'b0;
    end else if (drain_q) begin
      if (m_ready) begin
        if (m_last) drain_n = 1'b0;
        else        dptr_n  = dptr_q + 1'b1;
      end
    end else if (cnt_ok) begin
      count_n = (cnt_val <= 32'(FRAME_MAX)) ? cnt_val[CNT_W-1:0] : '0;
      wptr_n  = '0;
    end else if (wr_ok) begin
      if (wptr_q + 1'b1 == count_q) begin
        drain_n = 1'b1;
        dlen_n  = count_q;
        dptr_n  = '0;
        count_n = '0;
        wptr_n  = '0;
      end else begin
        wptr_n = wptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wptr_q  <= '0;
      dlen_q  <= '0;
      dptr_q  <= '0;
      drain_q <= 1'b0;
    end else begin
      count_q <= count_n;
      wptr_q  <= wptr_n;
      dlen_q  <= dlen_n;
      dptr_q  <= dptr_n;
      drain_q <= drain_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wptr_q] <= dat_val;
  end

  assign count = count_q;

endmodule

// File: rtl/nbx_byte_nic.sv
module nbx_byte_nic #(
  parameter int ADDR_W    = 8,
  parameter int FRAME_MAX = 1514
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        rxs_data,
  input  logic              rxs_valid,
  input  logic              rxs_last,
  output logic              rxs_ready,
  output logic [7:0]        txs_data,
  output logic              txs_valid,
  output logic              txs_last,
  input  logic              txs_ready,
  output logic              irq
);
  import nbx_pkg::*;

  localparam int CNT_W = $clog2(FRAME_MAX + 1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FRAME_MAX);

  logic             rst_sync_n;
  logic [5:0]       addr6;
  logic             unused_addr_hi;
  logic             rd_stb, wr_stb, ctl_rd, ctl_wr, soft_clr;
  logic             busy_q, busy_n, txd_q, txd_n, rxd_q, rxd_n, tst_q, tst_n;
  logic [31:0]      rdata_q, rdata_n, rd_val;
  logic             rx_active, rx_done, tx_sent, accept_ok;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic [7:0]       rx_byte;

  nbx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign addr6          = bus_addr[5:0];
  assign unused_addr_hi = ^bus_addr;
  assign rd_stb         = bus_sel & ~bus_wr;
  assign wr_stb         = bus_sel & bus_wr;
  assign ctl_rd         = rd_stb & (addr6 == OFS_INTCTL);
  assign ctl_wr         = wr_stb & (addr6 == OFS_INTCTL);
  assign soft_clr       = ctl_wr & ~bus_wdata[TXD_BIT] & ~bus_wdata[RXD_BIT]
                        & bus_wdata[TST_BIT];
  assign accept_ok      = ~busy_q & (rx_count < MAX_C);

  nbx_rx_path #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .soft_clr   (soft_clr),
    .accept_ok  (accept_ok),
    .s_data     (rxs_data),
    .s_valid    (rxs_valid),
    .s_last     (rxs_last),
    .s_ready    (rxs_ready),
    .active     (rx_active),
    .pop        (rd_stb & (addr6 == OFS_RXDATA)),
    .frame_done (rx_done),
    .count      (rx_count),
    .rd_byte    (rx_byte)
  );

  nbx_tx_path #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_clr (soft_clr),
    .cnt_wr   (wr_stb & (addr6 == OFS_TXCNT)),
    .cnt_val  (bus_wdata),
    .dat_wr   (wr_stb & (addr6 == OFS_TXDATA)),
    .dat_val  (bus_wdata[7:0]),
    .m_data   (txs_data),
    .m_valid  (txs_valid),
    .m_last   (txs_last),
    .m_ready  (txs_ready),
    .count    (tx_count),
    .sent     (tx_sent)
  );

  // flag and busy next state
  always_comb begin
    txd_n  = txd_q;
    rxd_n  = rxd_q;
    tst_n  = tst_q;
    busy_n = busy_q;
    if (ctl_rd) tst_n = 1'b0;
    if (ctl_wr) begin
      if (bus_wdata[TXD_BIT])      txd_n = 1'b0;
      else if (bus_wdata[RXD_BIT]) rxd_n = 1'b0;
      else if (bus_wdata[TST_BIT]) begin
        txd_n = 1'b0;
        rxd_n = 1'b0;
        tst_n = 1'b1;
      end
      busy_n = txd_n | rxd_n | tst_n;
    end
    if (rx_done) begin
      rxd_n  = 1'b1;
      busy_n = 1'b1;
    end
    if (tx_sent) begin
      txd_n  = 1'b1;
      busy_n = 1'b1;
    end
  end

  // read data select
  always_comb begin
    rd_val = '0;
    case (addr6)
      OFS_ID_HI:  rd_val = IDENT_HI;
      OFS_ID_LO:  rd_val = IDENT_LO;
      OFS_BUSY:   rd_val = {31'b0, busy_q};
      OFS_RXCNT:  rd_val = {{(32-CNT_W){1'b0}}, rx_count};
      OFS_TXCNT:  rd_val = {{(32-CNT_W){1'b0}}, tx_count};
      OFS_INTCTL: rd_val = {tst_q, 29'b0, rxd_q, txd_q};
      OFS_RXDATA: rd_val = (rx_count != '0) ? {24'b0, rx_byte} : 32'b0;
      default:    rd_val = '0;
    endcase
    rdata_n = rd_stb ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q  <= 1'b1;
      txd_q   <= 1'b0;
      rxd_q   <= 1'b0;
      tst_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_n;
      txd_q   <= txd_n;
      rxd_q   <= rxd_n;
      tst_q   <= tst_n;
      rdata_q <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = txd_q | rxd_q | tst_q;

endmodule

// File: rtl/nbx_byte_nic_chk.sv
module nbx_byte_nic_chk #(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_rd,
  input logic             soft_clr,
  input logic             tst_flag,
  input logic             busy,
  input logic             rx_active,
  input logic             rxs_ready,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             txs_valid,
  input logic             txs_ready,
  input logic             txs_last,
  input logic [7:0]       txs_data,
  input logic             irq
);

  // R7
  rx_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_active && (busy || rx_count >= CNT_W'(FRAME_MAX))) |-> !rxs_ready);

  // R4
  tst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> !tst_flag);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && !txs_ready && !soft_clr) |=> (txs_valid && $stable(txs_data)));

  // R12
  tx_done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && txs_ready && txs_last) |=> irq);

  // R9
  rx_cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(FRAME_MAX));

  // R11
  tx_cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CNT_W'(FRAME_MAX));

endmodule

bind nbx_byte_nic nbx_byte_nic_chk #(.FRAME_MAX(FRAME_MAX)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctl_rd    (ctl_rd),
  .soft_clr  (soft_clr),
  .tst_flag  (tst_q),
  .busy      (busy_q),
  .rx_active (rx_active),
  .rxs_ready (rxs_ready),
  .rx_count  (rx_count),
  .tx_count  (tx_count),
  .txs_valid (txs_valid),
  .txs_ready (txs_ready),
  .txs_last  (txs_last),
  .txs_data  (txs_data),
  .irq       (irq)
);

// File: tb/nbx_byte_nic_tb.sv
`timescale 1ns/1ps
module nbx_byte_nic_tb_top;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  rxs_data, txs_data;
  logic        rxs_valid, rxs_last, rxs_ready;
  logic        txs_valid, txs_last, txs_ready, irq;

  int n_chk = 0;
  int n_err = 0;

  nbx_byte_nic dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxs_data(rxs_data), .rxs_valid(rxs_valid), .rxs_last(rxs_last),
    .rxs_ready(rxs_ready), .txs_data(txs_data), .txs_valid(txs_valid),
    .txs_last(txs_last), .txs_ready(txs_ready), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {write, addr, wdata, expected read}
  localparam int NV = 22;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0, 32'h4D495053},  // R1
    {1'b0, 8'h04, 32'h0, 32'h4E455430},  // R1
    {1'b0, 8'h48, 32'h0, 32'h1},         // R1 mask, R2 busy
    {1'b0, 8'h0C, 32'h0, 32'h0},         // R2
    {1'b0, 8'h10, 32'h0, 32'h0},         // R2
    {1'b0, 8'h14, 32'h0, 32'h0},         // R2
    {1'b0, 8'h18, 32'h0, 32'h0},         // R1
    {1'b0, 8'h20, 32'h0, 32'h0},         // R1
    {1'b0, 8'h24, 32'h0, 32'h0},         // R1
    {1'b0, 8'h40, 32'h0, 32'h4D495053},  // R1
    {1'b1, 8'h14, 32'h0, 32'h0},         // R6
    {1'b0, 8'h08, 32'h0, 32'h0},         // R6
    {1'b1, 8'h10, 32'd1515, 32'h0},      // R11
    {1'b0, 8'h10, 32'h0, 32'h0},
    {1'b1, 8'h10, 32'd1514, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'd1514},
    {1'b1, 8'h10, 32'd7, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'd7},
    {1'b1, 8'h10, 32'd0, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0},
    {1'b1, 8'h20, 32'h55, 32'h0},        // R13
    {1'b0, 8'h10, 32'h0, 32'h0}
  };

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 7 + seed) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(int len, int seed);
    for (int i = 0; i < len; i++) begin
      rxs_data = pat(i, seed); rxs_last = (i == len - 1); rxs_valid = 1'b1;
      #1;
      while (!rxs_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    rxs_valid = 1'b0; rxs_last = 1'b0;
  endtask

  task automatic drain_tx(int n, int seed, output int bad);
    int k;
    k = 0; bad = 0;
    txs_ready = 1'b1;
    while (k < n) begin
      if (txs_valid) begin
        if (txs_data !== pat(k, seed) || txs_last !== (k == n - 1)) bad++;
        k++;
      end
      @(negedge clk);
    end
    txs_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int bad;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rxs_data = '0; rxs_valid = 1'b0; rxs_last = 1'b0; txs_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state at the pins
    check("R2 irq", {31'b0, irq}, 32'h0);
    check("R2 rxs_ready", {31'b0, rxs_ready}, 32'h0);
    check("R2 txs_valid", {31'b0, txs_valid}, 32'h0);

    // vector table: R1 R2 R6 R11 R13
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][72]) bus_write(VEC[v][71:64], VEC[v][63:32]);
      else begin
        bus_read(VEC[v][71:64], rd);
        check($sformatf("R1/R6/R11 vector %0d", v), rd, VEC[v][31:0]);
      end
    end

    // R8 R10: short frame in, read it back
    send_rx(6, 16);
    bus_read(8'h0C, rd); check("R8 rx count", rd, 32'd6);
    bus_read(8'h14, rd); check("R8 rx done flag", rd, 32'h2);
    check("R3 irq on rx done", {31'b0, irq}, 32'h1);
    bus_read(8'h08, rd); check("R8 busy", rd, 32'h1);
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      bus_read(8'h1C, rd); if (rd !== {24'b0, pat(i, 16)}) bad++;
    end
    check("R10 first bytes", bad, 0);
    bus_read(8'h0C, rd); check("R10 count decrement", rd, 32'd3);
    for (int i = 3; i < 6; i++) begin
      bus_read(8'h1C, rd); if (rd !== {24'b0, pat(i, 16)}) bad++;
    end
    check("R10 remaining bytes", bad, 0);
    bus_read(8'h1C, rd); check("R10 read at zero", rd, 32'h0);
    bus_read(8'h0C, rd); check("R10 count stays zero", rd, 32'h0);

    // R7 refused while busy
    rxs_valid = 1'b1; rxs_data = 8'hEE; rxs_last = 1'b1;
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); #1; if (rxs_ready) bad++; end
    rxs_valid = 1'b0; rxs_last = 1'b0;
    check("R7 ready low while busy", bad, 0);

    // R12 R13 transmit with stalled sink
    bus_write(8'h10, 32'd4);
    for (int i = 0; i < 4; i++) bus_write(8'h20, {24'h1A1, pat(i, 40)} & 32'h1FF);
    check("R12 valid after final write", {31'b0, txs_valid}, 32'h1);
    bus_read(8'h14, rd); check("R12 tx done not early", rd, 32'h2);
    bus_read(8'h10, rd); check("R12 count zero after fill", rd, 32'h0);
    bus_write(8'h10, 32'd9);
    bus_write(8'h20, 32'h77);
    bus_read(8'h10, rd); check("R13 count write ignored in drain", rd, 32'h0);
    drain_tx(4, 40, bad);
    check("R12 outbound bytes and last", bad, 0);
    bus_read(8'h14, rd); check("R12 tx done after last", rd, 32'h3);
    bus_read(8'h08, rd); check("R12 busy", rd, 32'h1);

    // R5 R6 acknowledge priority
    bus_write(8'h14, 32'h8000_0003);
    bus_read(8'h14, rd); check("R5 only tx done cleared", rd, 32'h2);
    bus_write(8'h14, 32'h8000_0002);
    bus_read(8'h14, rd); check("R5 only rx done cleared", rd, 32'h0);
    bus_read(8'h08, rd); check("R6 busy drops", rd, 32'h0);

    // R9 truncation, R7 full buffer
    send_rx(1520, 3);
    bus_read(8'h0C, rd); check("R9 count stops at limit", rd, 32'd1514);
    bus_write(8'h14, 32'h2);
    rxs_valid = 1'b1; rxs_data = 8'h11; rxs_last = 1'b1;
    bad = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); #1; if (rxs_ready) bad++; end
    rxs_valid = 1'b0; rxs_last = 1'b0;
    check("R7 ready low when buffer full", bad, 0);
    bad = 0;
    for (int i = 0; i < 1514; i++) begin
      bus_read(8'h1C, rd); if (rd !== {24'b0, pat(i, 3)}) bad++;
    end
    check("R9 stored bytes", bad, 0);
    #1; check("R7 ready once drained", {31'b0, rxs_ready}, 32'h1);

    // R14 R4 R3 soft reset and test flag
    send_rx(3, 9);
    bus_write(8'h10, 32'd5);
    bus_write(8'h14, 32'h8000_0000);
    bus_read(8'h0C, rd); check("R14 rx count cleared", rd, 32'h0);
    bus_read(8'h10, rd); check("R14 tx count cleared", rd, 32'h0);
    bus_read(8'h08, rd); check("R14 busy set", rd, 32'h1);
    check("R3 irq on test flag", {31'b0, irq}, 32'h1);
    bus_read(8'h14, rd); check("R4 test flag read", rd, 32'h8000_0000);
    bus_read(8'h14, rd); check("R4 test flag cleared", rd, 32'h0);
    check("R3 irq low", {31'b0, irq}, 32'h0);
    #1; check("R14 refuses after soft reset", {31'b0, rxs_ready}, 32'h0);
    bus_write(8'h14, 32'h0);
    #1; check("R6 zero write releases busy", {31'b0, rxs_ready}, 32'h1);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule